// File: doc/BRIEF.md
# Converter Serial Port with Daisy-Chain and Busy Start Bit

This block is a synthesizable behavioural model of the digital side of a serial-output sampling converter. It serves as a partner in a testbench or as an emulation target. A parallel sample arrives on `sample_i`. The host drives the convert strobe, the serial clock and the serial data input. The block answers on a serial data output that has a separate output-enable. All inputs are taken as levels that are synchronous to `clk`. Edges are found by comparing each input with its value one clock earlier.

A rising edge on the convert strobe starts a conversion timer of `CONV_CYCLES` clocks. At that same edge the block picks its port behaviour:

- **Select mode.** The device is selected while the strobe is low. It can put a start bit in front of the data to mark that the result is ready.
- **Chain mode.** The output is always driven. Bits from an upstream device enter behind the local result, so several devices act as one long shift register.

When the timer expires, the result register loads `sample_i`. From then on, every falling serial-clock edge seen while the strobe is low moves the stream by one bit, most significant bit first.

Top module: `adc_chain_port`

## Requirements
- R1: After reset, with the strobe held high, `sdo_oe` is 0 and `sdo` is 0. No conversion starts at reset release.
- R2: A clock edge where `cnv` is 1 and was 0 one clock earlier is an accepted rise when no conversion is running. It picks select mode if `sdi` was 1 one clock before that edge and chain mode if `sdi` was 0.
- R3: When `sdi` is driven with the same waveform as `cnv`, every accepted rise picks chain mode.
- R4: While `turbo` is 1, an accepted rise always picks select mode.
- R5: The result register loads `sample_i` on the clock edge that comes exactly `CONV_CYCLES` clocks after the accepted rise. Between those edges, in select mode with the strobe low, `sdo` is driven 0.
- R6: A strobe rise while a conversion is running is ignored. It changes neither the mode nor the moment the result loads.
- R7: In select mode with `turbo` at 0, a start bit is armed if `cnv` or `sdi` is 0 on the loading edge. While armed, `sdo` is 1. The first falling serial-clock edge with the strobe low clears it and does not shift the data.
- R8: If the start bit is not armed, `sdo` shows the result MSB right after the load.
- R9: Each clock edge where `sck` is 0, `sck` was 1 one clock earlier, and `cnv` is 0, moves the next lower bit to `sdo`. In select mode the bits that follow the LSB are 0.
- R10: In chain mode, `sdi` is sampled at each such falling edge and enters behind the data. After `DATA_W` shifts, the first upstream bit is on `sdo`.
- R11: `sdo_oe` is 1 in chain mode at all times. In select mode it equals the inverse of `cnv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; all other inputs are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv | input | 1 | Convert strobe and active-low select |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Mode select level and upstream chain data |
| turbo | input | 1 | Fast-conversion flag; forces select mode and suppresses the start bit |
| sample_i | input | DATA_W | Parallel result captured when the conversion ends |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for `sdo` (0 models high impedance) |

## Verification
Select-mode readback runs from a table that mixes all-ones, alternating, single-bit and edge-value samples, with and without the start bit. A dropped bit, a reversed order or a misplaced start bit each gives a different serial stream. Chain mode is tried with an upstream pattern that differs from the local sample, which separates zero fill from true pass-through. The tied `sdi`/strobe case and the turbo case with `sdi` low each try to select the opposite mode. A strobe pulse in the middle of a conversion shows whether the load time or the mode moves.

// File: rtl/adc_chain_pkg.sv
package adc_chain_pkg;
  typedef enum logic {
    MODE_CHAIN = 1'b0,
    MODE_SEL   = 1'b1
  } port_mode_e;
endpackage

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_chain_pkg::*;
#(
  parameter int CONV_CYCLES = 20,
  parameter int CNT_W       = $clog2(CONV_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnv_rise,
  input  logic       sdi_prev,
  input  logic       turbo,
  input  logic       cnv,
  input  logic       sdi,
  output port_mode_e mode,
  output logic       active,
  output logic       load,
  output logic       start_set
);
  port_mode_e       mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             active_q, active_d;

  assign load      = active_q && (cnt_q == CNT_W'(1));
  assign start_set = load && (mode_q == MODE_SEL) && !turbo && (!cnv || !sdi);
  assign mode      = mode_q;
  assign active    = active_q;

  always_comb begin
    mode_d   = mode_q;
    cnt_d    = cnt_q;
    active_d = active_q;
    if (!active_q) begin
      if (cnv_rise) begin
        // level of sdi one clock before the edge decides; turbo overrides chain
        mode_d   = (sdi_prev || turbo) ? MODE_SEL : MODE_CHAIN;
        cnt_d    = CNT_W'(CONV_CYCLES);
        active_d = 1'b1;
      end
    end else if (load) begin
      cnt_d    = '0;
      active_d = 1'b0;
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_SEL;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      cnt_q    <= cnt_d;
      active_q <= active_d;
    end
  end
endmodule

// File: rtl/adc_shift_path.sv
module adc_shift_path #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] sample,
  input  logic              start_set,
  input  logic              start_clr,
  input  logic              shift_en,
  input  logic              shift_in,
  output logic              msb,
  output logic              start
);
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              start_q, start_d;

  always_comb begin
    sh_d    = sh_q;
    start_d = start_q;
    if (load) begin
      sh_d    = sample;
      start_d = start_set;
    end else begin
      if (start_clr) start_d = 1'b0;
      if (shift_en) begin
        if (start_q) start_d = 1'b0;
        else         sh_d    = {sh_q[DATA_W-2:0], shift_in};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      start_q <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      start_q <= start_d;
    end
  end

  assign msb   = sh_q[DATA_W-1];
  assign start = start_q;
endmodule

// File: rtl/adc_chain_port.sv
module adc_chain_port
  import adc_chain_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int CONV_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv,
  input  logic              sck,
  input  logic              sdi,
  input  logic              turbo,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);

  logic       cnv_q, sck_q, sdi_q;
  logic       cnv_rise, sck_fall, shift_en, shift_in;
  logic       load, start_set, start, msb, conv_active, mode_sel;
  port_mode_e mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_q <= 1'b1;
      sck_q <= 1'b0;
      sdi_q <= 1'b1;
    end else begin
      cnv_q <= cnv;
      sck_q <= sck;
      sdi_q <= sdi;
    end
  end

  assign cnv_rise = cnv && !cnv_q;
  assign sck_fall = !sck && sck_q;
  assign shift_en = sck_fall && !cnv;
  assign mode_sel = (mode == MODE_SEL);
  assign shift_in = mode_sel ? 1'b0 : sdi;

  adc_conv_ctrl #(.CONV_CYCLES(CONV_CYCLES), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cnv_rise(cnv_rise), .sdi_prev(sdi_q),
    .turbo(turbo), .cnv(cnv), .sdi(sdi), .mode(mode),
    .active(conv_active), .load(load), .start_set(start_set)
  );

  adc_shift_path #(.DATA_W(DATA_W)) path_i (
    .clk(clk), .rst_n(rst_n), .load(load), .sample(sample_i),
    .start_set(start_set), .start_clr(cnv_rise), .shift_en(shift_en),
    .shift_in(shift_in), .msb(msb), .start(start)
  );

  always_comb begin
    if (start)                         sdo = 1'b1;
    else if (conv_active && mode_sel)  sdo = 1'b0;
    else                               sdo = msb;
  end

  assign sdo_oe = !mode_sel || !cnv;
endmodule

// File: rtl/adc_chain_port_chk.sv
module adc_chain_port_chk #(
  parameter int CONV_CYCLES = 20
) (
  input logic clk,
  input logic rst_n,
  input logic cnv,
  input logic sdi,
  input logic turbo,
  input logic sdo,
  input logic sdo_oe,
  input logic mode_sel,
  input logic conv_active
);
  localparam int RW = $clog2(CONV_CYCLES + 1) + 1;
  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_cnt <= '0;
    else if (conv_active) run_cnt <= run_cnt + RW'(1);
    else                  run_cnt <= '0;
  end

  assert_conv_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_active |-> (run_cnt < RW'(CONV_CYCLES)));

  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_active && $past(conv_active)) |-> $stable(mode_sel));

  assert_chain_pick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cnv) && !$past(sdi) && !turbo && !conv_active) |=> !mode_sel);

  assert_turbo_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cnv) && turbo && !conv_active) |=> mode_sel);

  assert_busy_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_active && mode_sel && !cnv) |-> (sdo_oe && !sdo));
endmodule

bind adc_chain_port adc_chain_port_chk #(.CONV_CYCLES(CONV_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnv(cnv), .sdi(sdi), .turbo(turbo),
  .sdo(sdo), .sdo_oe(sdo_oe), .mode_sel(mode_sel), .conv_active(conv_active)
);

// File: tb/adc_chain_port_tb_top.sv
module adc_chain_port_tb_top;
  localparam int DW   = 14;
  localparam int CONV = 20;

  logic clk, rst_n, cnv, sck, sdi, turbo;
  logic [DW-1:0] sample_i;
  logic sdo, sdo_oe;
  int n_cmp = 0, n_bad = 0, cyc = 0;

  adc_chain_port #(.DATA_W(DW), .CONV_CYCLES(CONV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdi),
    .turbo(turbo), .sample_i(sample_i), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // bit 15: end conversion with strobe low (start bit expected); 13:0 sample
  localparam logic [15:0] VEC [4] = '{
    16'h3FFF, 16'h9555, 16'h2001 | 16'h0000, 16'h8001
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic pulse_sck();
    sck = 1'b1; @(negedge clk);
    sck = 1'b0; @(negedge clk);
  endtask

  // accepted rise with sdi at level lvl one clock before
  task automatic start_conv(input logic lvl, input logic [DW-1:0] s);
    sdi = lvl; sample_i = s; @(negedge clk);
    cnv = 1'b1; @(negedge clk);
  endtask

  task automatic read_sel(input logic [DW-1:0] s, input logic busy);
    if (busy) begin
      chk(sdo, 1'b1, "R7 start bit");
      pulse_sck();
    end
    for (int k = DW - 1; k >= 0; k--) begin
      chk(sdo, s[k], busy ? "R9 data after start" : "R8/R9 data");
      pulse_sck();
    end
    chk(sdo, 1'b0, "R9 zero fill");
  endtask

  initial begin
    rst_n = 1'b0; cnv = 1'b1; sck = 1'b0; sdi = 1'b1; turbo = 1'b0;
    sample_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sdo_oe, 1'b0, "R1 oe after reset");
    chk(sdo, 1'b0, "R1 sdo after reset");
    cnv = 1'b0; @(negedge clk);
    chk(sdo, 1'b0, "R1 no conversion at release");

    // table walk: select mode readback
    for (int v = 0; v < 4; v++) begin
      logic busy;
      busy = VEC[v][15];
      start_conv(1'b1, VEC[v][DW-1:0]);
      chk(sdo_oe, 1'b0, "R11 oe low while strobe high");
      if (busy) cnv = 1'b0;
      repeat (CONV + 1) @(negedge clk);
      if (!busy) begin
        cnv = 1'b0; @(negedge clk);
      end
      chk(sdo_oe, 1'b1, "R11 oe high while selected");
      read_sel(VEC[v][DW-1:0], busy);
    end

    // R5 timing and R6 ignored mid-conversion rise
    start_conv(1'b1, 14'h2A5C);
    cnv = 1'b0;
    for (int k = 1; k < CONV; k++) begin
      if (k == 5) begin sdi = 1'b0; cnv = 1'b1; end
      if (k == 6) begin sdi = 1'b1; cnv = 1'b0; end
      @(negedge clk);
    end
    chk(sdo, 1'b0, "R5 busy low before load");
    @(negedge clk);
    chk(sdo, 1'b1, "R5/R6 load on time with start bit");
    cnv = 1'b1; #1;
    chk(sdo_oe, 1'b0, "R6 mode kept select");
    cnv = 1'b0; @(negedge clk);
    read_sel(14'h2A5C, 1'b1);

    // R2/R10 chain pass-through
    begin
      logic [DW-1:0] s, u;
      s = 14'h1234; u = 14'h2CB1;
      start_conv(1'b0, s);
      chk(sdo_oe, 1'b1, "R11 chain oe with strobe high");
      repeat (CONV + 1) @(negedge clk);
      cnv = 1'b0; @(negedge clk);
      chk(sdo, s[DW-1], "R2 chain no start bit");
      for (int k = DW - 1; k >= 0; k--) begin
        chk(sdo, s[k], "R10 local data");
        sdi = u[k];
        pulse_sck();
      end
      for (int k = DW - 1; k >= 0; k--) begin
        chk(sdo, u[k], "R10 upstream data");
        pulse_sck();
      end
    end

    // R3 sdi tied to strobe
    sdi = 1'b0; cnv = 1'b0; @(negedge clk);
    sample_i = 14'h3001;
    cnv = 1'b1; sdi = 1'b1; @(negedge clk);
    repeat (CONV + 1) @(negedge clk);
    chk(sdo_oe, 1'b1, "R3 tied picks chain");
    chk(sdo, 1'b1, "R3 data without start bit");
    cnv = 1'b0; sdi = 1'b0; @(negedge clk);

    // R4 turbo forces select and no start bit
    turbo = 1'b1;
    start_conv(1'b0, 14'h0F0F);
    chk(sdo_oe, 1'b0, "R4 turbo picks select");
    cnv = 1'b0;
    repeat (CONV + 1) @(negedge clk);
    chk(sdo, 1'b0, "R4 no start bit, MSB 0");
    read_sel(14'h0F0F, 1'b0);
    turbo = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule